// File: doc/BRIEF.md
# Two-Level Prioritized Vectored Interrupt Controller

This block sits between five interrupt sources and a processor core. Four sources arrive as flags on a single bus: external 0, timer 0, external 1 and timer 1. The fifth source is serial, and it is pending when either its transmit-done flag or its receive-done flag is set. A request counts only when the global enable bit and the source's own enable bit are both set. A per-source priority bit puts each source in the high or the low level. Within a level, a fixed order breaks ties.

When a request may be taken, the block raises `irq_req`. The core answers with `irq_accept`. On the cycle after the accept, the block shows a one-hot acknowledge and the fixed vector address of the chosen source, for that one cycle only. The block keeps one in-service bit per level, so a high-level request can preempt a low-level service. A request at the same level or a lower level waits. The core pulses `irq_ret` to release the highest active level.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset both configuration registers read 0, and `irq_req`, `irq_ack`, `irq_vec` and `svc_level` are all 0.
- R2: A write with `cfg_sel`=0 loads the enable register and a write with `cfg_sel`=1 loads the priority register. Enable bits 6:5 and priority bits 7:5 always read 0, whatever is written to them.
- R3: A source is eligible only when enable bit 7 (global) and its own enable bit are both 1. The own enable bits are bit 0 for external 0, bit 1 for timer 0, bit 2 for external 1, bit 3 for timer 1 and bit 4 for serial.
- R4: The serial source is pending when `ser_tx_done` or `ser_rx_done` is 1.
- R5: An eligible source whose priority bit is 1 is chosen over any eligible source whose priority bit is 0. Priority bit positions match the enable bit positions (bits 4:0).
- R6: Among eligible sources at the same level, the choice follows the order external 0, timer 0, external 1, timer 1, serial.
- R7: The vector addresses are 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial.
- R8: The cycle after an edge where `irq_accept` and `irq_req` are both 1, `irq_ack` is one-hot and `irq_vec` holds the matching vector. The acknowledge bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. In every other cycle both outputs are 0.
- R9: An accepted grant sets the in-service bit of its level: `svc_level` bit 0 for low, bit 1 for high.
- R10: While the high level is in service, `irq_req` stays 0. While only the low level is in service, `irq_req` is raised only for an eligible high-priority source.
- R11: `irq_ret` clears the high in-service bit if it is set, and otherwise clears the low bit. When a return and an accept fall on the same edge, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 priority |
| cfg_wdata | input | 8 | Write data |
| cfg_en_rd | output | 8 | Enable register contents |
| cfg_pri_rd | output | 8 | Priority register contents |
| src_flags | input | 4 | Flags for external 0, timer 0, external 1 and timer 1 (bits 0..3) |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| irq_req | output | 1 | Interrupt request to the core |
| irq_accept | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_ack | output | 5 | One-hot acknowledge of the taken source |
| irq_vec | output | 16 | Vector address of the taken source |
| svc_level | output | 2 | In-service bits: bit 0 low level, bit 1 high level |

## Verification
An accept and a return can land on the same clock edge. When that happens, the in-service tracker must clear one level and set the other in a single update. The bench provokes this by first taking a low-level source. It then raises a high-priority source and pulses `irq_accept` and `irq_ret` together. It judges the result by requiring `svc_level` to read 2'b10 and the serial acknowledge to appear on the next cycle. A separate case makes a request arrive on the same edge as a configuration write. For that case the bench checks that arbitration uses the register value written on that edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NSRC = 5;

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] pri;
    } cfg_t;

endpackage

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs
    import ivc_pkg::*;
#(
    parameter logic [7:0] EN_MASK  = 8'h9F,
    parameter logic [7:0] PRI_MASK = 8'h1F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       sel,
    input  logic [7:0] wdata,
    output cfg_t       cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (sel) cfg_d.pri = wdata & PRI_MASK;
            else     cfg_d.en  = wdata & EN_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en_bits,
    input  logic         global_en,
    input  logic [N-1:0] pri_bits,
    input  logic [1:0]   svc,
    output logic [N-1:0] grant,
    output logic         grant_hi,
    output logic         grant_valid
);

    logic [N-1:0] elig;
    logic [N-1:0] hi_cand;
    logic [N-1:0] lo_cand;
    logic [N-1:0] hi_first;
    logic [N-1:0] lo_first;
    logic         hi_ok;
    logic         lo_ok;

    assign elig    = pend & en_bits & {N{global_en}};
    assign hi_cand = elig & pri_bits;
    assign lo_cand = elig & ~pri_bits;
    assign hi_ok   = !svc[1];
    assign lo_ok   = !svc[1] && !svc[0];

    for (genvar i = 0; i < N; i++) begin : g_first
        localparam logic [N-1:0] BELOW = N'((1 << i) - 1);
        assign hi_first[i] = hi_cand[i] && ((hi_cand & BELOW) == '0);
        assign lo_first[i] = lo_cand[i] && ((lo_cand & BELOW) == '0);
    end

    always_comb begin
        grant       = '0;
        grant_hi    = 1'b0;
        grant_valid = 1'b0;
        if (hi_ok && (hi_cand != '0)) begin
            grant       = hi_first;
            grant_hi    = 1'b1;
            grant_valid = 1'b1;
        end else if (lo_ok && (lo_cand != '0)) begin
            grant       = lo_first;
            grant_valid = 1'b1;
        end
    end

endmodule

// File: rtl/ivc_svc_track.sv
module ivc_svc_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_hi,
    input  logic       ret,
    output logic [1:0] svc_q
);

    logic [1:0] svc_d;

    always_comb begin
        svc_d = svc_q;
        if (ret) begin
            if (svc_q[1]) svc_d[1] = 1'b0;
            else          svc_d[0] = 1'b0;
        end
        if (take) begin
            if (take_hi) svc_d[1] = 1'b1;
            else         svc_d[0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          VEC_BASE   = 3,
    parameter int          VEC_STRIDE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_sel,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_en_rd,
    output logic [7:0]           cfg_pri_rd,
    input  logic [NSRC-2:0]      src_flags,
    input  logic                 ser_tx_done,
    input  logic                 ser_rx_done,
    output logic                 irq_req,
    input  logic                 irq_accept,
    input  logic                 irq_ret,
    output logic [NSRC-1:0]      irq_ack,
    output logic [ADDR_W-1:0]    irq_vec,
    output logic [1:0]           svc_level
);

    localparam int GLOBAL_BIT = 7;

    typedef struct packed {
        logic [NSRC-1:0]   ack;
        logic [ADDR_W-1:0] vec;
    } out_t;

    cfg_t            cfg_q;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] grant;
    logic            grant_hi;
    logic            grant_valid;
    logic            take;
    out_t            out_d;
    out_t            out_q;

    ivc_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    assign pend = {ser_tx_done | ser_rx_done, src_flags};

    ivc_arbiter #(.N(NSRC)) u_arb (
        .pend        (pend),
        .en_bits     (cfg_q.en[NSRC-1:0]),
        .global_en   (cfg_q.en[GLOBAL_BIT]),
        .pri_bits    (cfg_q.pri[NSRC-1:0]),
        .svc         (svc_level),
        .grant       (grant),
        .grant_hi    (grant_hi),
        .grant_valid (grant_valid)
    );

    assign take = irq_accept && grant_valid;

    ivc_svc_track u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .take_hi (grant_hi),
        .ret     (irq_ret),
        .svc_q   (svc_level)
    );

    always_comb begin
        out_d = '0;
        if (take) begin
            out_d.ack = grant;
            for (int i = 0; i < NSRC; i++) begin
                if (grant[i]) out_d.vec = ADDR_W'(VEC_BASE + VEC_STRIDE * i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_req    = grant_valid;
    assign irq_ack    = out_q.ack;
    assign irq_vec    = out_q.vec;
    assign cfg_en_rd  = cfg_q.en;
    assign cfg_pri_rd = cfg_q.pri;

endmodule

module irq_vec_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cfg_en_rd,
    input logic [7:0]  cfg_pri_rd,
    input logic        irq_req,
    input logic        irq_accept,
    input logic        irq_ret,
    input logic [4:0]  irq_ack,
    input logic [15:0] irq_vec,
    input logic [1:0]  svc_level
);

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_rd[6:5] == 2'b00 && cfg_pri_rd[7:5] == 3'b000); // R2

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en_rd[7] |-> !irq_req); // R3

    AST_EXT0_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack[0] |-> irq_vec == 16'h0003); // R7

    AST_SER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack[4] |-> irq_vec == 16'h0023); // R7

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && irq_req) |=> $onehot(irq_ack)); // R8

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_accept && irq_req) |=> irq_ack == 5'd0 && irq_vec == 16'd0); // R8

    AST_TAKE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && irq_req) |=> svc_level != 2'b00); // R9

    AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_level[1] |-> !irq_req); // R10

    AST_RET_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && svc_level[1] && !irq_accept) |=> !svc_level[1]); // R11

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en_rd  (cfg_en_rd),
    .cfg_pri_rd (cfg_pri_rd),
    .irq_req    (irq_req),
    .irq_accept (irq_accept),
    .irq_ret    (irq_ret),
    .irq_ack    (irq_ack),
    .irq_vec    (irq_vec),
    .svc_level  (svc_level)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;

    localparam int PERIOD = 10;
    localparam int NV     = 10;
    // {enable, priority, flags[4:0] (bit4 = serial via tx), expected ack}
    localparam logic [25:0] TBL [NV] = '{
        {8'h1F, 8'h00, 5'h1F, 5'h00},  // R3 global off
        {8'h9F, 8'h00, 5'h1F, 5'h01},  // R6 ext0 first
        {8'h9F, 8'h00, 5'h1E, 5'h02},  // R6 timer0 next
        {8'h9F, 8'h10, 5'h1F, 5'h10},  // R5 serial high
        {8'h9F, 8'h0C, 5'h1F, 5'h04},  // R5 R6 ext1 first of highs
        {8'h9E, 8'h00, 5'h01, 5'h00},  // R3 own enable off
        {8'h90, 8'h00, 5'h10, 5'h10},  // R4 serial only
        {8'h9F, 8'h1F, 5'h18, 5'h08},  // R6 timer1 over serial
        {8'h88, 8'h00, 5'h08, 5'h08},  // R3 timer1 alone
        {8'h80, 8'h1F, 5'h1F, 5'h00}   // R3 no own enables
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_en_rd;
    logic [7:0]  cfg_pri_rd;
    logic [3:0]  src_flags = '0;
    logic        ser_tx_done = 1'b0;
    logic        ser_rx_done = 1'b0;
    logic        irq_req;
    logic        irq_accept = 1'b0;
    logic        irq_ret = 1'b0;
    logic [4:0]  irq_ack;
    logic [15:0] irq_vec;
    logic [1:0]  svc_level;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD / 2) clk = ~clk;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_en_rd(cfg_en_rd), .cfg_pri_rd(cfg_pri_rd),
        .src_flags(src_flags), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
        .irq_req(irq_req), .irq_accept(irq_accept), .irq_ret(irq_ret),
        .irq_ack(irq_ack), .irq_vec(irq_vec), .svc_level(svc_level)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input logic [4:0] oh);
        logic [15:0] v = 16'h0;
        for (int i = 0; i < 5; i++) if (oh[i]) v = 16'(3 + 8 * i);
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic set_flags(input logic [4:0] f);
        src_flags = f[3:0];
        ser_tx_done = f[4];
        ser_rx_done = 1'b0;
    endtask

    task automatic accept();
        irq_accept = 1'b1;
        tick();
        irq_accept = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 3);
        #1;
        // R1 reset state
        check("R1 en", 16'(cfg_en_rd), 16'h0);
        check("R1 pri", 16'(cfg_pri_rd), 16'h0);
        check("R1 req", 16'(irq_req), 16'h0);
        check("R1 vec", irq_vec, 16'h0);
        rst_n = 1'b1;
        tick();
        check("R1 ack", 16'(irq_ack), 16'h0);
        check("R1 svc", 16'(svc_level), 16'h0);

        for (int k = 0; k < NV; k++) begin
            logic [4:0] exp_ack;
            exp_ack = TBL[k][4:0];
            wr(1'b0, TBL[k][25:18]);
            wr(1'b1, TBL[k][17:10]);
            set_flags(TBL[k][9:5]);
            #1;
            check($sformatf("R3 R5 R6 req vector %0d", k), 16'(irq_req), 16'(exp_ack != 0));
            if (exp_ack != 0) begin
                accept();
                check($sformatf("R8 ack vector %0d", k), 16'(irq_ack), 16'(exp_ack));
                check($sformatf("R7 vec vector %0d", k), irq_vec, vec_of(exp_ack));
                set_flags(5'h0);
                ret();
                check($sformatf("R11 svc vector %0d", k), 16'(svc_level), 16'h0);
            end
            set_flags(5'h0);
        end

        // R2 reserved bits and register select
        wr(1'b0, 8'hFF);
        check("R2 enable read", 16'(cfg_en_rd), 16'h009F);
        wr(1'b1, 8'hFF);
        check("R2 priority read", 16'(cfg_pri_rd), 16'h001F);
        check("R2 enable untouched", 16'(cfg_en_rd), 16'h009F);

        // R4 receive flag alone raises serial
        wr(1'b1, 8'h00);
        ser_rx_done = 1'b1;
        #1;
        check("R4 rx req", 16'(irq_req), 16'h1);
        accept();
        check("R4 rx ack", 16'(irq_ack), 16'h10);
        check("R9 low svc", 16'(svc_level), 16'h1);
        tick();
        check("R8 ack one cycle", 16'(irq_ack), 16'h0);
        check("R8 vec one cycle", irq_vec, 16'h0);
        ser_rx_done = 1'b0;
        // R10 low in service blocks other low
        src_flags = 4'b0010;
        #1;
        check("R10 low blocks low", 16'(irq_req), 16'h0);
        // R10 high preempts low
        wr(1'b1, 8'h01);
        src_flags = 4'b0011;
        #1;
        check("R10 high preempts", 16'(irq_req), 16'h1);
        accept();
        check("R9 high ack", 16'(irq_ack), 16'h01);
        check("R9 both levels", 16'(svc_level), 16'h3);
        check("R10 high blocks all", 16'(irq_req), 16'h0);
        ret();
        check("R11 clears high first", 16'(svc_level), 16'h1);
        ret();
        check("R11 clears low", 16'(svc_level), 16'h0);
        src_flags = 4'b0000;

        // R11 return and accept on the same edge
        wr(1'b1, 8'h10);
        src_flags = 4'b0001;
        #1;
        accept();
        check("R11 setup low", 16'(svc_level), 16'h1);
        src_flags = 4'b0000;
        ser_tx_done = 1'b1;
        #1;
        irq_accept = 1'b1; irq_ret = 1'b1;
        tick();
        irq_accept = 1'b0; irq_ret = 1'b0;
        check("R11 same edge svc", 16'(svc_level), 16'h2);
        check("R11 same edge ack", 16'(irq_ack), 16'h10);
        ser_tx_done = 1'b0;
        ret();
        check("R11 final svc", 16'(svc_level), 16'h0);

        // R3 write on the same edge as a request uses the new value
        wr(1'b0, 8'h00);
        src_flags = 4'b0100;
        wr(1'b0, 8'h84);
        check("R3 write then req", 16'(irq_req), 16'h1);
        src_flags = 4'b0000;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule